// File: doc/BRIEF.md
# SCSI Initiator Arbitration and Selection Sequencer

This block runs the bus-acquisition phase of an initiator select command. A one-cycle start pulse latches the command code, the initiator's own bus ID and the target ID. The block then waits until the bus is free and arbitrates with its own ID, retrying whenever arbitration cannot start or is lost. After winning, it raises a selection request toward the target and waits for the target to confirm or for the selection timeout to run out.

Every step of the sequence is deferred by a cycle-count delay. The block performs a step's action in one cycle, loads a timer, and carries out the next step on the cycle after the timer expires. The step that follows a won arbitration comes from a small step table. Each table entry holds a state, a step number and the interrupt-status bits to report if that step fails.

A failed selection loads the entry's step number into the sequence-step output and ORs its status bits into the interrupt status. A confirmed selection moves to the next table entry. That entry is a placeholder that signals done. Command, message and data phases are handled elsewhere.

Top module: `sel_seq`

## Requirements
- R1: After reset, all request outputs, `done_o`, `seq_step_o` and `int_stat_o` are zero.
- R2: `start_i` is accepted only while the block is idle, and the first bus-free check runs in the cycle after acceptance. A start pulse during a running sequence changes neither its timing nor the latched command and IDs.
- R3: In a bus-free check cycle with `bus_free_i` high, the arbitration request follows FREE+SETTLE+1 cycles later. With `bus_free_i` low, the bus-free check repeats FREE+1 cycles later.
- R4: `arb_req_o` pulses for one cycle with `arb_id_o` equal to the own ID. If `arb_ok_i` is low in that cycle, `release_o` pulses in the same cycle and a new bus-free check runs CLEAR+1 cycles later.
- R5: Arbitration is evaluated ARB+1 cycles after the request. If `arb_won_i` is high, the selection request follows CLEAR+SETTLE+1 cycles later. If it is low, `release_o` pulses and a bus-free check runs CLEAR+1 cycles later.
- R6: `sel_req_o` pulses for one cycle with `sel_id_o` equal to the target ID. `atn_o` is high with it unless the command code is 8'h41 (select without attention). `atn_o` is never high without `sel_req_o`.
- R7: A `sel_cfm_i` pulse whose `sel_cfm_id_i` equals the target ID, arriving 1 to SELTO cycles after the selection request, cancels the timeout. `done_o` then pulses 3 cycles after the confirmation, with `seq_step_o` and `int_stat_o` unchanged. A confirmation carrying any other ID has no effect.
- R8: Without a matching confirmation, `release_o` pulses SELTO+1 cycles after the selection request. In the next cycle `done_o` pulses, `seq_step_o` reads 2, and bits 8'h10 (service request) and 8'h08 (successful operation) are ORed into `int_stat_o`. Those bits stay set until reset, and no other bit is ever set.
- R9: `done_o` is a single-cycle pulse, and `seq_step_o` changes only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, used only when idle |
| cmd_i | input | 8 | Command code, latched at launch |
| own_id_i | input | ID_W | Initiator bus ID, latched at launch |
| tgt_id_i | input | ID_W | Target bus ID, latched at launch |
| bus_free_i | input | 1 | Sampled bus phase is bus free |
| arb_ok_i | input | 1 | Arbitration could begin (valid with arb_req_o) |
| arb_won_i | input | 1 | Arbitration result, sampled at arbitration end |
| sel_cfm_i | input | 1 | Selection confirmation pulse |
| sel_cfm_id_i | input | ID_W | ID carried by the confirmation |
| arb_req_o | output | 1 | Begin-arbitration request pulse |
| arb_id_o | output | ID_W | ID used for arbitration |
| sel_req_o | output | 1 | Begin-selection request pulse |
| sel_id_o | output | ID_W | Target ID for selection |
| atn_o | output | 1 | Assert attention with the selection |
| release_o | output | 1 | Release control lines pulse |
| seq_step_o | output | 3 | Sequence step reported on failure |
| int_stat_o | output | 8 | Accumulated interrupt-status bits |
| done_o | output | 1 | Sequence finished pulse |

## Verification
The assertions assume that `arb_ok_i` responds combinationally in the cycle `arb_req_o` is high, and that `arb_won_i` and `bus_free_i` are stable levels at the edge where the block samples them. The bench changes these levels only at falling edges, in cycles where the sequencer is waiting on its timer. Confirmations are one-cycle pulses placed inside the selection window, including the window's last cycle where the timeout expires. The bench also drives stray confirmations and starts while the block is idle or busy, to exercise the cases where an input must be ignored.

// File: rtl/sel_seq_pkg.sv
package sel_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUS_FREE,
    ST_ARB_BEGIN,
    ST_ARB_END,
    ST_SEL_BEGIN,
    ST_SEL_END,
    ST_CMD_BEGIN,
    ST_CMD_DONE
  } seq_state_e;

  typedef struct packed {
    seq_state_e  state;
    logic [2:0]  step;
    logic [7:0]  status;
  } step_ent_t;

  localparam logic [7:0] CMD_SEL_NO_ATN = 8'h41;
  localparam logic [7:0] IST_SVC_REQ    = 8'h10;
  localparam logic [7:0] IST_OK         = 8'h08;

  localparam int unsigned STEP_ENTRIES = 3;
  localparam int unsigned STEP_IDX_W   = $clog2(STEP_ENTRIES + 1);

  localparam step_ent_t ENT_NONE = '{state: ST_IDLE, step: 3'd0, status: 8'h00};

  function automatic step_ent_t step_entry(input int unsigned idx);
    step_ent_t e;
    e.status = IST_SVC_REQ | IST_OK;
    case (idx)
      0:       begin e.state = ST_SEL_BEGIN; e.step = 3'd2; end
      1:       begin e.state = ST_CMD_BEGIN; e.step = 3'd3; end
      2:       begin e.state = ST_CMD_DONE;  e.step = 3'd4; end
      default: e = ENT_NONE;
    endcase
    return e;
  endfunction

  function automatic int unsigned dmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sel_seq_timer.sv
module sel_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         cancel_i,
  output logic         run_o,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  assign expired_o = run_q && (cnt_q == '0);
  assign run_o     = run_q;

  // val_i >= 1: expiry lands val_i cycles after the load edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= val_i - W'(1);
    end else if (cancel_i || expired_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/sel_seq_steps.sv
module sel_seq_steps
  import sel_seq_pkg::*;
(
  input  logic [STEP_IDX_W-1:0] idx_i,
  output step_ent_t             ent_o
);
  localparam int unsigned SLOTS = 1 << STEP_IDX_W;

  step_ent_t tbl [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_ent
    if (g < STEP_ENTRIES) begin : g_used
      assign tbl[g] = step_entry(g);
    end else begin : g_pad
      assign tbl[g] = ENT_NONE;
    end
  end

  assign ent_o = tbl[idx_i];
endmodule

// File: rtl/sel_seq.sv
module sel_seq
  import sel_seq_pkg::*;
#(
  parameter int unsigned FREE_CYC   = 20,
  parameter int unsigned SETTLE_CYC = 10,
  parameter int unsigned CLEAR_CYC  = 20,
  parameter int unsigned ARB_CYC    = 60,
  parameter int unsigned SELTO_CYC  = 6250000,
  parameter int unsigned ID_W       = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [7:0]      cmd_i,
  input  logic [ID_W-1:0] own_id_i,
  input  logic [ID_W-1:0] tgt_id_i,
  input  logic            bus_free_i,
  input  logic            arb_ok_i,
  input  logic            arb_won_i,
  input  logic            sel_cfm_i,
  input  logic [ID_W-1:0] sel_cfm_id_i,
  output logic            arb_req_o,
  output logic [ID_W-1:0] arb_id_o,
  output logic            sel_req_o,
  output logic [ID_W-1:0] sel_id_o,
  output logic            atn_o,
  output logic            release_o,
  output logic [2:0]      seq_step_o,
  output logic [7:0]      int_stat_o,
  output logic            done_o
);
  localparam int unsigned D_FS = FREE_CYC + SETTLE_CYC;
  localparam int unsigned D_CS = CLEAR_CYC + SETTLE_CYC;
  localparam int unsigned MAXD = dmax(dmax(D_FS, D_CS), dmax(ARB_CYC, SELTO_CYC));
  localparam int unsigned TW   = $clog2(MAXD + 1);

  seq_state_e            state_q, state_d, pend_q, pend_d;
  logic [7:0]            cmd_q;
  logic [ID_W-1:0]       own_q, tgt_q;
  logic [STEP_IDX_W-1:0] idx_q, idx_d, rom_idx;
  logic                  sel_ok_q, sel_ok_d;
  logic [2:0]            step_q, step_d;
  logic [7:0]            ist_q, ist_d;
  logic                  done_q, done_d;
  logic                  accept;

  logic                  tmr_load, tmr_cancel, tmr_run, tmr_exp;
  logic [TW-1:0]         tmr_val;
  logic                  cfm_hit;
  step_ent_t             ent;

  sel_seq_timer #(.W(TW)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .cancel_i  (tmr_cancel),
    .run_o     (tmr_run),
    .expired_o (tmr_exp)
  );

  // on a confirmed selection the table is read one entry ahead
  assign rom_idx = idx_q + STEP_IDX_W'((state_q == ST_SEL_END) && sel_ok_q);

  sel_seq_steps i_steps (
    .idx_i (rom_idx),
    .ent_o (ent)
  );

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign cfm_hit = (state_q == ST_SEL_BEGIN) && tmr_run && sel_cfm_i && (sel_cfm_id_i == tgt_q);

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    idx_d      = idx_q;
    sel_ok_d   = sel_ok_q;
    step_d     = step_q;
    ist_d      = ist_q;
    done_d     = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    tmr_cancel = 1'b0;
    arb_req_o  = 1'b0;
    sel_req_o  = 1'b0;
    release_o  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_d  = ST_BUS_FREE;
        idx_d    = '0;
        sel_ok_d = 1'b0;
      end
    end else if (cfm_hit) begin
      tmr_cancel = 1'b1;
      sel_ok_d   = 1'b1;
      state_d    = ST_SEL_END;
    end else if (tmr_exp) begin
      state_d = pend_q;
    end else if (!tmr_run) begin
      unique case (state_q)
        ST_BUS_FREE: begin
          tmr_load = 1'b1;
          if (bus_free_i) begin
            pend_d  = ST_ARB_BEGIN;
            tmr_val = TW'(D_FS);
          end else begin
            pend_d  = ST_BUS_FREE;
            tmr_val = TW'(FREE_CYC);
          end
        end
        ST_ARB_BEGIN: begin
          arb_req_o = 1'b1;
          tmr_load  = 1'b1;
          if (arb_ok_i) begin
            pend_d  = ST_ARB_END;
            tmr_val = TW'(ARB_CYC);
          end else begin
            release_o = 1'b1;
            pend_d    = ST_BUS_FREE;
            tmr_val   = TW'(CLEAR_CYC);
          end
        end
        ST_ARB_END: begin
          tmr_load = 1'b1;
          if (arb_won_i) begin
            pend_d  = ent.state;
            tmr_val = TW'(D_CS);
          end else begin
            release_o = 1'b1;
            pend_d    = ST_BUS_FREE;
            tmr_val   = TW'(CLEAR_CYC);
          end
        end
        ST_SEL_BEGIN: begin
          sel_req_o = 1'b1;
          tmr_load  = 1'b1;
          pend_d    = ST_SEL_END;
          tmr_val   = TW'(SELTO_CYC);
        end
        ST_SEL_END: begin
          if (sel_ok_q) begin
            idx_d   = rom_idx;
            state_d = ent.state;
          end else begin
            step_d    = ent.step;
            ist_d     = ist_q | ent.status;
            release_o = 1'b1;
            done_d    = 1'b1;
            state_d   = ST_IDLE;
          end
        end
        ST_CMD_BEGIN, ST_CMD_DONE: begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pend_q   <= ST_IDLE;
      idx_q    <= '0;
      sel_ok_q <= 1'b0;
      step_q   <= '0;
      ist_q    <= '0;
      done_q   <= 1'b0;
      cmd_q    <= '0;
      own_q    <= '0;
      tgt_q    <= '0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      idx_q    <= idx_d;
      sel_ok_q <= sel_ok_d;
      step_q   <= step_d;
      ist_q    <= ist_d;
      done_q   <= done_d;
      if (accept) begin
        cmd_q <= cmd_i;
        own_q <= own_id_i;
        tgt_q <= tgt_id_i;
      end
    end
  end

  assign arb_id_o   = own_q;
  assign sel_id_o   = tgt_q;
  assign atn_o      = sel_req_o && (cmd_q != CMD_SEL_NO_ATN);
  assign seq_step_o = step_q;
  assign int_stat_o = ist_q;
  assign done_o     = done_q;
endmodule

// File: rtl/sel_seq_chk.sv
module sel_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       arb_req_o,
  input logic       sel_req_o,
  input logic       atn_o,
  input logic       release_o,
  input logic       done_o,
  input logic [2:0] seq_step_o,
  input logic [7:0] int_stat_o
);
  AST_ARB_PULSE:   assert property (@(posedge clk_i) disable iff (!rst_ni) arb_req_o |=> !arb_req_o); // R4
  AST_SEL_PULSE:   assert property (@(posedge clk_i) disable iff (!rst_ni) sel_req_o |=> !sel_req_o); // R6
  AST_ATN_IN_SEL:  assert property (@(posedge clk_i) disable iff (!rst_ni) atn_o |-> sel_req_o); // R6
  AST_SEL_NO_REL:  assert property (@(posedge clk_i) disable iff (!rst_ni) sel_req_o |-> !release_o && !arb_req_o); // R5
  AST_DONE_PULSE:  assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R9
  AST_STEP_HOLD:   assert property (@(posedge clk_i) disable iff (!rst_ni) !done_o |-> $stable(seq_step_o)); // R9
  AST_INT_STICKY:  assert property (@(posedge clk_i) disable iff (!rst_ni) (int_stat_o & $past(int_stat_o)) == $past(int_stat_o)); // R8
  AST_INT_BITS:    assert property (@(posedge clk_i) disable iff (!rst_ni) (int_stat_o & 8'he7) == 8'h00); // R8
endmodule

bind sel_seq sel_seq_chk i_sel_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .arb_req_o  (arb_req_o),
  .sel_req_o  (sel_req_o),
  .atn_o      (atn_o),
  .release_o  (release_o),
  .done_o     (done_o),
  .seq_step_o (seq_step_o),
  .int_stat_o (int_stat_o)
);

// File: tb/test_sel_seq.sv
`timescale 1ns/1ps
module test_sel_seq;
  localparam int F = 3, S = 2, C = 4, A = 5, T = 40;
  localparam logic [2:0] OWN = 3'd6;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       start_i = 1'b0, bus_free_i = 1'b0, arb_ok_i = 1'b0, arb_won_i = 1'b0, sel_cfm_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic [2:0] own_id_i = OWN, tgt_id_i = 3'd0, sel_cfm_id_i = 3'd0;
  logic       arb_req_o, sel_req_o, atn_o, release_o, done_o;
  logic [2:0] arb_id_o, sel_id_o, seq_step_o;
  logic [7:0] int_stat_o;

  sel_seq #(.FREE_CYC(F), .SETTLE_CYC(S), .CLEAR_CYC(C), .ARB_CYC(A), .SELTO_CYC(T), .ID_W(3)) i_sel_seq (
    .clk_i, .rst_ni, .start_i, .cmd_i, .own_id_i, .tgt_id_i, .bus_free_i, .arb_ok_i, .arb_won_i,
    .sel_cfm_i, .sel_cfm_id_i, .arb_req_o, .arb_id_o, .sel_req_o, .sel_id_o, .atn_o, .release_o,
    .seq_step_o, .int_stat_o, .done_o
  );

  always #10 clk_i = ~clk_i;

  typedef struct { int kind; int cyc; int data; string req; } ev_t;
  ev_t exp_q[$];
  int  total = 0, bad = 0, cyc = 0;
  int  exp_step = 0, exp_int = 0;
  bit  mon_on = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic push_ev(input int kind, input int at, input int data, input string req);
    ev_t e;
    e.kind = kind; e.cyc = at; e.data = data; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // monitor: compare each observed pulse against the queue head
  task automatic observe(input int kind, input int data);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2 unexpected event", kind * 1000 + data, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind && e.cyc == cyc && e.data == data, e.req,
            (kind << 24) | (cyc << 12) | data, (e.kind << 24) | (e.cyc << 12) | e.data);
    end
  endtask

  initial forever begin
    @(negedge clk_i);
    #2;
    if (mon_on) begin
      if (arb_req_o) observe(0, int'(arb_id_o));
      if (sel_req_o) observe(1, int'({atn_o, sel_id_o}));
      if (release_o) observe(2, 0);
      if (done_o)    observe(3, int'({seq_step_o, int_stat_o}));
    end
  end

  task automatic wait_cyc(input int at);
    @(negedge clk_i);
    while (cyc < at) @(negedge clk_i);
  endtask

  // sig: 0 bus_free, 1 arb_ok, 2 arb_won, 3 confirm pulse, 4 stray start
  task automatic sched(input int at, input int sig, input int val);
    fork
      begin
        wait_cyc(at);
        case (sig)
          0: bus_free_i = val[0];
          1: arb_ok_i   = val[0];
          2: arb_won_i  = val[0];
          3: begin sel_cfm_i = 1'b1; sel_cfm_id_i = val[2:0]; @(negedge clk_i); sel_cfm_i = 1'b0; end
          default: begin
            start_i = 1'b1; cmd_i = 8'h42; tgt_id_i = val[2:0];
            @(negedge clk_i); start_i = 1'b0;
          end
        endcase
      end
    join_none
  endtask

  task automatic run_sel(input logic [7:0] cmd, input logic [2:0] tid, input int busy_n,
                         input int fail_n, input int lose_n, input int cfm_k,
                         input logic [2:0] cfm_id, input bit stray, input string tag);
    int s, t, a, b, c, d, end_c;
    bit atn;
    @(negedge clk_i);
    bus_free_i = (busy_n == 0); arb_ok_i = (fail_n == 0); arb_won_i = (lose_n == 0);
    cmd_i = cmd; tgt_id_i = tid; start_i = 1'b1;
    s = cyc;
    atn = (cmd != 8'h41);
    t = s + 1;
    for (int i = 0; i < busy_n; i++) begin
      t += F + 1;
      if (i == busy_n - 1) sched(t - 1, 0, 1);
    end
    a = t + F + S + 1;                                   // R3
    for (int i = 0; i < fail_n; i++) begin
      push_ev(0, a, OWN, {"R4 arb request ", tag});
      push_ev(2, a, 0, {"R4 release on no-begin ", tag});
      if (i == fail_n - 1) sched(a + 1, 1, 1);
      a = a + C + 1 + F + S + 1;
    end
    push_ev(0, a, OWN, {"R3 arb request ", tag});
    b = a + A + 1;
    for (int i = 0; i < lose_n; i++) begin
      push_ev(2, b, 0, {"R5 release on loss ", tag});
      if (i == lose_n - 1) sched(b + 1, 2, 1);
      a = b + C + 1 + F + S + 1;
      push_ev(0, a, OWN, {"R5 arb retry ", tag});
      b = a + A + 1;
    end
    c = b + C + S + 1;
    push_ev(1, c, int'({atn, tid}), {"R6 selection ", tag});
    if (stray) sched(s + 3, 4, int'(tid + 3'd1));
    if (cfm_k > 0) sched(c + cfm_k, 3, int'(cfm_id));
    if (cfm_k > 0 && cfm_id == tid) begin
      end_c = c + cfm_k + 3;
      push_ev(3, end_c, (exp_step << 8) | exp_int, {"R7 done after confirm ", tag});
    end else begin
      d = c + T + 1;
      push_ev(2, d, 0, {"R8 release on timeout ", tag});
      exp_step = 2;
      exp_int  = exp_int | 8'h18;
      end_c = d + 1;
      push_ev(3, end_c, (exp_step << 8) | exp_int, {"R8 done on timeout ", tag});
    end
    @(negedge clk_i);
    start_i = 1'b0;
    wait_cyc(end_c + 2);
    check(exp_q.size() == 0, {"R2 missing events ", tag}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    // R1 reset state
    check(seq_step_o == 3'd0, "R1 seq_step reset", seq_step_o, 0);
    check(int_stat_o == 8'h00, "R1 int_stat reset", int_stat_o, 0);
    check(!done_o && !arb_req_o && !sel_req_o && !release_o && !atn_o, "R1 pulses reset",
          {done_o, arb_req_o, sel_req_o, release_o, atn_o}, 0);
    mon_on = 1'b1;

    run_sel(8'h41, 3'd3, 0, 0, 0, 6, 3'd3, 1'b0, "confirm ok");
    run_sel(8'h41, 3'd5, 0, 0, 0, 0, 3'd0, 1'b0, "timeout");
    run_sel(8'h42, 3'd1, 0, 0, 0, 10, 3'd4, 1'b0, "wrong-id confirm ignored (R7) atn");
    run_sel(8'h41, 3'd2, 2, 0, 0, 0, 3'd0, 1'b0, "bus busy twice");
    run_sel(8'h41, 3'd4, 0, 1, 0, 0, 3'd0, 1'b0, "arb cannot begin");
    run_sel(8'h42, 3'd0, 0, 0, 2, 5, 3'd0, 1'b0, "arb lost twice");
    run_sel(8'h41, 3'd7, 1, 0, 0, 8, 3'd7, 1'b1, "stray start ignored (R2)");
    run_sel(8'h41, 3'd1, 0, 0, 0, T, 3'd1, 1'b0, "confirm at last cycle");
    run_sel(8'h41, 3'd1, 0, 0, 0, 1, 3'd1, 1'b0, "confirm at first cycle");

    // idle: confirm and bus inputs produce nothing; status holds
    @(negedge clk_i);
    sel_cfm_i = 1'b1; sel_cfm_id_i = 3'd1; bus_free_i = 1'b1; arb_ok_i = 1'b1; arb_won_i = 1'b1;
    @(negedge clk_i);
    sel_cfm_i = 1'b0;
    repeat (20) @(negedge clk_i);
    #2;
    check(exp_q.size() == 0, "R2 idle stays idle", exp_q.size(), 0);
    check(int_stat_o == 8'h18, "R8 int sticky", int_stat_o, 8'h18);
    check(seq_step_o == 3'd2, "R8 step held", seq_step_o, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule